// File: doc/BRIEF.md
# Bus-to-Accelerator Access Bridge

This block is a Wishbone slave placed in front of a streaming accelerator. The accelerator has a register/coefficient port in AXI-Lite form and two AXI-Stream ports, one for input samples and one for output samples. The bridge examines each Wishbone cycle and sends it to one of three destinations: an AXI-Lite write or read, a single input-stream beat pushed toward the engine, or a single output-stream beat pulled from the engine. The Wishbone cycle is held and is acknowledged only after the matching AXI handshake has finished.

Only one AXI operation is in progress at any time. A sequencer takes a request in `Q_IDLE`, passes it to either the register-channel controller or the stream controller (`Q_LITE` / `Q_STREAM`), raises the acknowledge for one cycle in `Q_ACK`, and then returns to `Q_IDLE`. Each Wishbone access moves exactly one sample in or out, so the rate of bus accesses sets the stream rate. Sequencer transitions: `Q_IDLE→Q_LITE` on a register access; `Q_IDLE→Q_STREAM` on a push or a pull; `Q_IDLE→Q_ACK` on an in-window access that maps to nothing; `Q_LITE→Q_ACK` and `Q_STREAM→Q_ACK` when the sub-controller completes; `Q_ACK→Q_IDLE` always.

Register controller states and transitions: `L_IDLE→L_WRITE` on a write start; `L_IDLE→L_RADDR` on a read start; `L_WRITE→L_IDLE` once both the address and data channels have been accepted; `L_RADDR→L_RDATA` on arready; `L_RDATA→L_IDLE` on rvalid. Stream controller states and transitions: `P_IDLE→P_PUSH` on a push start; `P_IDLE→P_WAIT` on a pull start; `P_PUSH→P_IDLE` on in_tready; `P_WAIT→P_TAKE` on out_tvalid; `P_TAKE→P_IDLE` always.

Top module: `wb_axi_bridge`

## Requirements
- R1: Only accesses whose address bits 31..16 equal 0x3000 are served. Any other address receives no acknowledge and produces no AXI activity.
- R2: A Wishbone write to offset 0x00, 0x10, 0x14, or any offset from 0x80 up to 0xFFF (offset = address bits 15..0) raises awvalid and wvalid together. awaddr is the offset bits 11..0, wdata is the bus data and wstrb is wb_sel. Each valid stays high with stable content until its own ready is seen.
- R3: A Wishbone read from one of the register offsets listed in R2 holds arvalid with araddr = offset bits 11..0 until arready. It then holds rready until rvalid and returns rdata on the acknowledge.
- R4: A Wishbone write to offset 0x40 holds in_tvalid with in_tdata = bus data, stable, until in_tready. The acknowledge follows that beat.
- R5: A Wishbone read from offset 0x44 waits for out_tvalid, raises out_tready for exactly one cycle while out_tvalid is high, and returns that beat's data on the acknowledge.
- R6: Every push or pull access moves exactly one stream beat.
- R7: Any other in-window access (write to 0x44, read of 0x40, or any unlisted offset, including 0x1000 and above) is acknowledged on the first clock edge after it is presented. It reads as zero and leaves every AXI signal and all queued stream data untouched.
- R8: At most one AXI operation is active at a time, and the acknowledge is a single-cycle pulse. With a ready or valid that answers at once, the acknowledge is seen 3 cycles after the request for a register write or a push. It is seen 5 cycles after the request for a register read. Each cycle of extra delay on the AXI side adds one cycle.
- R9: After reset, wb_ack, every AXI valid and every AXI ready driven by the bridge are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_sel | input | DATA_W/8 | Wishbone byte selects |
| wb_adr | input | ADDR_W | Wishbone address |
| wb_dat_w | input | DATA_W | Wishbone write data |
| wb_dat_r | output | DATA_W | Wishbone read data |
| wb_ack | output | 1 | Wishbone acknowledge |
| axi_awvalid | output | 1 | Register write address valid |
| axi_awready | input | 1 | Register write address ready |
| axi_awaddr | output | LITE_AW | Register write address |
| axi_wvalid | output | 1 | Register write data valid |
| axi_wready | input | 1 | Register write data ready |
| axi_wdata | output | DATA_W | Register write data |
| axi_wstrb | output | DATA_W/8 | Register write strobes |
| axi_arvalid | output | 1 | Register read address valid |
| axi_arready | input | 1 | Register read address ready |
| axi_araddr | output | LITE_AW | Register read address |
| axi_rvalid | input | 1 | Register read data valid |
| axi_rready | output | 1 | Register read data ready |
| axi_rdata | input | DATA_W | Register read data |
| in_tvalid | output | 1 | Input-sample stream valid |
| in_tready | input | 1 | Input-sample stream ready |
| in_tdata | output | DATA_W | Input-sample stream data |
| out_tvalid | input | 1 | Output-sample stream valid |
| out_tready | output | 1 | Output-sample stream ready |
| out_tdata | input | DATA_W | Output-sample stream data |

## Verification
Register writes are tried with the address and data ready delays equal, with the address channel late, and with the data channel late. The acknowledge latency shows whether the bridge waits for the slower channel, and whether a channel accepted early is held or re-driven. Reads are tried with no delay and with delays on both the address and data phases, which separates waiting for arready from waiting for rvalid. Pushes use several tready delays, and pulls are tried with the sample already waiting and with the sample arriving late; the results show whether the bridge sends exactly one beat each time. Out-of-window, wrong-direction and unlisted offsets are mixed with queued output data, so that an access that wrongly consumes a sample can be told apart from one that is correctly ignored.

// File: rtl/wbax_pkg.sv
package wbax_pkg;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_LITE_WR,
        RT_LITE_RD,
        RT_PUSH,
        RT_PULL,
        RT_NULL
    } route_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_LITE,
        Q_STREAM,
        Q_ACK
    } seq_state_e;

    typedef enum logic [1:0] {
        L_IDLE,
        L_WRITE,
        L_RADDR,
        L_RDATA
    } lite_state_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_PUSH,
        P_WAIT,
        P_TAKE
    } strm_state_e;

    localparam int OFS_W = 16;

    localparam logic [OFS_W-1:0] OFS_CTRL    = 16'h0000;
    localparam logic [OFS_W-1:0] OFS_LEN     = 16'h0010;
    localparam logic [OFS_W-1:0] OFS_TAPS    = 16'h0014;
    localparam logic [OFS_W-1:0] OFS_PUSH    = 16'h0040;
    localparam logic [OFS_W-1:0] OFS_PULL    = 16'h0044;
    localparam logic [OFS_W-1:0] OFS_COEF_LO = 16'h0080;

endpackage

// File: rtl/wbax_decode.sv
module wbax_decode
    import wbax_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LITE_AW = 12,
    parameter logic [ADDR_W-OFS_W-1:0] WIN_BASE = '0
) (
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    adr,
    output route_e               route,
    output logic [LITE_AW-1:0]   lite_addr
);

    localparam logic [OFS_W:0] LITE_SPAN = (OFS_W+1)'(1) << LITE_AW;

    logic             win_hit;
    logic [OFS_W-1:0] offset;
    logic             is_reg;
    logic             is_coef;

    assign win_hit   = (adr[ADDR_W-1:OFS_W] == WIN_BASE);
    assign offset    = adr[OFS_W-1:0];
    assign is_coef   = (offset >= OFS_COEF_LO) && ({1'b0, offset} < LITE_SPAN);
    assign is_reg    = (offset == OFS_CTRL) || (offset == OFS_LEN) ||
                       (offset == OFS_TAPS) || is_coef;
    assign lite_addr = offset[LITE_AW-1:0];

    always_comb begin
        route = RT_NONE;
        if (req && win_hit) begin
            if (is_reg) begin
                route = we ? RT_LITE_WR : RT_LITE_RD;
            end else if ((offset == OFS_PUSH) && we) begin
                route = RT_PUSH;
            end else if ((offset == OFS_PULL) && !we) begin
                route = RT_PULL;
            end else begin
                route = RT_NULL;
            end
        end
    end

endmodule

// File: rtl/wbax_lite_master.sv
module wbax_lite_master
    import wbax_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LITE_AW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_wr,
    input  logic                  start_rd,
    input  logic [LITE_AW-1:0]    req_addr,
    input  logic [DATA_W-1:0]     req_data,
    input  logic [DATA_W/8-1:0]   req_strb,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  awvalid,
    input  logic                  awready,
    output logic [LITE_AW-1:0]    awaddr,
    output logic                  wvalid,
    input  logic                  wready,
    output logic [DATA_W-1:0]     wdata,
    output logic [DATA_W/8-1:0]   wstrb,
    output logic                  arvalid,
    input  logic                  arready,
    output logic [LITE_AW-1:0]    araddr,
    input  logic                  rvalid,
    output logic                  rready,
    input  logic [DATA_W-1:0]     rdata
);

    lite_state_e          state_q, state_d;
    logic                 aw_ok_q, w_ok_q;
    logic                 wr_fin;
    logic [LITE_AW-1:0]   addr_q;
    logic [DATA_W-1:0]    data_q;
    logic [DATA_W/8-1:0]  strb_q;

    assign wr_fin = (aw_ok_q || awready) && (w_ok_q || wready);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_IDLE: begin
                if (start_wr)      state_d = L_WRITE;
                else if (start_rd) state_d = L_RADDR;
            end
            L_WRITE: if (wr_fin)  state_d = L_IDLE;
            L_RADDR: if (arready) state_d = L_RDATA;
            L_RDATA: if (rvalid)  state_d = L_IDLE;
            default:              state_d = L_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aw_ok_q <= 1'b0;
            w_ok_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            strb_q  <= '0;
        end else begin
            if (state_q == L_IDLE && (start_wr || start_rd)) begin
                addr_q <= req_addr;
                data_q <= req_data;
                strb_q <= req_strb;
            end
            if (state_q == L_WRITE) begin
                if (wr_fin) begin
                    aw_ok_q <= 1'b0;
                    w_ok_q  <= 1'b0;
                end else begin
                    if (awready) aw_ok_q <= 1'b1;
                    if (wready)  w_ok_q  <= 1'b1;
                end
            end
        end
    end

    assign awvalid = (state_q == L_WRITE) && !aw_ok_q;
    assign wvalid  = (state_q == L_WRITE) && !w_ok_q;
    assign awaddr  = addr_q;
    assign wdata   = data_q;
    assign wstrb   = strb_q;
    assign arvalid = (state_q == L_RADDR);
    assign araddr  = addr_q;
    assign rready  = (state_q == L_RDATA);
    assign rd_data = rdata;
    assign done    = ((state_q == L_WRITE) && wr_fin) ||
                     ((state_q == L_RDATA) && rvalid);

endmodule

// File: rtl/wbax_stream_port.sv
module wbax_stream_port
    import wbax_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_push,
    input  logic               start_pull,
    input  logic [DATA_W-1:0]  push_data,
    output logic               done,
    output logic [DATA_W-1:0]  pull_data,
    output logic               in_tvalid,
    input  logic               in_tready,
    output logic [DATA_W-1:0]  in_tdata,
    input  logic               out_tvalid,
    output logic               out_tready,
    input  logic [DATA_W-1:0]  out_tdata
);

    strm_state_e        state_q, state_d;
    logic [DATA_W-1:0]  sample_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: begin
                if (start_push)      state_d = P_PUSH;
                else if (start_pull) state_d = P_WAIT;
            end
            P_PUSH: if (in_tready)  state_d = P_IDLE;
            P_WAIT: if (out_tvalid) state_d = P_TAKE;
            P_TAKE:                 state_d = P_IDLE;
            default:                state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= P_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else if (state_q == P_IDLE && start_push) begin
            sample_q <= push_data;
        end
    end

    assign in_tvalid  = (state_q == P_PUSH);
    assign in_tdata   = sample_q;
    assign out_tready = (state_q == P_TAKE);
    assign pull_data  = out_tdata;
    assign done       = ((state_q == P_PUSH) && in_tready) || (state_q == P_TAKE);

endmodule

// File: rtl/wb_axi_bridge.sv
module wb_axi_bridge
    import wbax_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LITE_AW = 12,
    parameter logic [ADDR_W-OFS_W-1:0] WIN_BASE = 16'h3000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wb_cyc,
    input  logic                  wb_stb,
    input  logic                  wb_we,
    input  logic [DATA_W/8-1:0]   wb_sel,
    input  logic [ADDR_W-1:0]     wb_adr,
    input  logic [DATA_W-1:0]     wb_dat_w,
    output logic [DATA_W-1:0]     wb_dat_r,
    output logic                  wb_ack,
    output logic                  axi_awvalid,
    input  logic                  axi_awready,
    output logic [LITE_AW-1:0]    axi_awaddr,
    output logic                  axi_wvalid,
    input  logic                  axi_wready,
    output logic [DATA_W-1:0]     axi_wdata,
    output logic [DATA_W/8-1:0]   axi_wstrb,
    output logic                  axi_arvalid,
    input  logic                  axi_arready,
    output logic [LITE_AW-1:0]    axi_araddr,
    input  logic                  axi_rvalid,
    output logic                  axi_rready,
    input  logic [DATA_W-1:0]     axi_rdata,
    output logic                  in_tvalid,
    input  logic                  in_tready,
    output logic [DATA_W-1:0]     in_tdata,
    input  logic                  out_tvalid,
    output logic                  out_tready,
    input  logic [DATA_W-1:0]     out_tdata
);

    seq_state_e          seq_q, seq_d;
    route_e              route;
    logic [LITE_AW-1:0]  lite_addr;
    logic                idle;
    logic                lite_done, strm_done;
    logic [DATA_W-1:0]   lite_rd, strm_rd;
    logic                is_read_q;
    logic [DATA_W-1:0]   rd_q;

    wbax_decode #(
        .ADDR_W   (ADDR_W),
        .LITE_AW  (LITE_AW),
        .WIN_BASE (WIN_BASE)
    ) decode_i (
        .req       (wb_cyc && wb_stb),
        .we        (wb_we),
        .adr       (wb_adr),
        .route     (route),
        .lite_addr (lite_addr)
    );

    assign idle = (seq_q == Q_IDLE);

    wbax_lite_master #(
        .DATA_W  (DATA_W),
        .LITE_AW (LITE_AW)
    ) lite_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (idle && route == RT_LITE_WR),
        .start_rd (idle && route == RT_LITE_RD),
        .req_addr (lite_addr),
        .req_data (wb_dat_w),
        .req_strb (wb_sel),
        .done     (lite_done),
        .rd_data  (lite_rd),
        .awvalid  (axi_awvalid),
        .awready  (axi_awready),
        .awaddr   (axi_awaddr),
        .wvalid   (axi_wvalid),
        .wready   (axi_wready),
        .wdata    (axi_wdata),
        .wstrb    (axi_wstrb),
        .arvalid  (axi_arvalid),
        .arready  (axi_arready),
        .araddr   (axi_araddr),
        .rvalid   (axi_rvalid),
        .rready   (axi_rready),
        .rdata    (axi_rdata)
    );

    wbax_stream_port #(
        .DATA_W (DATA_W)
    ) strm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_push (idle && route == RT_PUSH),
        .start_pull (idle && route == RT_PULL),
        .push_data  (wb_dat_w),
        .done       (strm_done),
        .pull_data  (strm_rd),
        .in_tvalid  (in_tvalid),
        .in_tready  (in_tready),
        .in_tdata   (in_tdata),
        .out_tvalid (out_tvalid),
        .out_tready (out_tready),
        .out_tdata  (out_tdata)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            Q_IDLE: begin
                unique case (route)
                    RT_LITE_WR, RT_LITE_RD: seq_d = Q_LITE;
                    RT_PUSH, RT_PULL:       seq_d = Q_STREAM;
                    RT_NULL:                seq_d = Q_ACK;
                    default:                seq_d = Q_IDLE;
                endcase
            end
            Q_LITE:   if (lite_done) seq_d = Q_ACK;
            Q_STREAM: if (strm_done) seq_d = Q_ACK;
            Q_ACK:    seq_d = Q_IDLE;
            default:  seq_d = Q_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= Q_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read_q <= 1'b0;
            rd_q      <= '0;
        end else begin
            unique case (seq_q)
                Q_IDLE: begin
                    is_read_q <= (route == RT_LITE_RD) || (route == RT_PULL);
                    rd_q      <= '0;
                end
                Q_LITE: begin
                    if (lite_done) rd_q <= is_read_q ? lite_rd : '0;
                end
                Q_STREAM: begin
                    if (strm_done) rd_q <= is_read_q ? strm_rd : '0;
                end
                default: ;
            endcase
        end
    end

    assign wb_ack   = (seq_q == Q_ACK);
    assign wb_dat_r = rd_q;

endmodule

// File: rtl/wbax_checker.sv
module wbax_checker #(
    parameter int DATA_W = 32,
    parameter int LITE_AW = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wb_ack,
    input logic                axi_awvalid,
    input logic                axi_awready,
    input logic [LITE_AW-1:0]  axi_awaddr,
    input logic                axi_wvalid,
    input logic                axi_wready,
    input logic [DATA_W-1:0]   axi_wdata,
    input logic                axi_arvalid,
    input logic                axi_arready,
    input logic [LITE_AW-1:0]  axi_araddr,
    input logic                axi_rready,
    input logic                in_tvalid,
    input logic                in_tready,
    input logic [DATA_W-1:0]   in_tdata,
    input logic                out_tvalid,
    input logic                out_tready
);

    // R2
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (axi_awvalid && !axi_awready) |=> (axi_awvalid && $stable(axi_awaddr)));

    // R2
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (axi_wvalid && !axi_wready) |=> (axi_wvalid && $stable(axi_wdata)));

    // R3
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (axi_arvalid && !axi_arready) |=> (axi_arvalid && $stable(axi_araddr)));

    // R4
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tvalid && !in_tready) |=> (in_tvalid && $stable(in_tdata)));

    // R5
    pull_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_tready |=> !out_tready);

    // R5
    pull_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_tready |-> out_tvalid);

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    // R8
    one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({axi_awvalid || axi_wvalid, axi_arvalid || axi_rready, in_tvalid, out_tready}));

    // R8
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> !(axi_awvalid || axi_wvalid || axi_arvalid || axi_rready || in_tvalid || out_tready));

endmodule

bind wb_axi_bridge wbax_checker #(
    .DATA_W  (DATA_W),
    .LITE_AW (LITE_AW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_ack      (wb_ack),
    .axi_awvalid (axi_awvalid),
    .axi_awready (axi_awready),
    .axi_awaddr  (axi_awaddr),
    .axi_wvalid  (axi_wvalid),
    .axi_wready  (axi_wready),
    .axi_wdata   (axi_wdata),
    .axi_arvalid (axi_arvalid),
    .axi_arready (axi_arready),
    .axi_araddr  (axi_araddr),
    .axi_rready  (axi_rready),
    .in_tvalid   (in_tvalid),
    .in_tready   (in_tready),
    .in_tdata    (in_tdata),
    .out_tvalid  (out_tvalid),
    .out_tready  (out_tready)
);

// File: tb/wb_axi_bridge_tb.sv
`timescale 1ns/1ps
module wb_axi_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [3:0]  wb_sel = '0;
    logic [31:0] wb_adr = '0, wb_dat_w = '0;
    logic [31:0] wb_dat_r;
    logic        wb_ack;
    logic        axi_awvalid, axi_awready;
    logic [11:0] axi_awaddr;
    logic        axi_wvalid, axi_wready;
    logic [31:0] axi_wdata;
    logic [3:0]  axi_wstrb;
    logic        axi_arvalid, axi_arready;
    logic [11:0] axi_araddr;
    logic        axi_rvalid, axi_rready;
    logic [31:0] axi_rdata;
    logic        in_tvalid, in_tready;
    logic [31:0] in_tdata;
    logic        out_tvalid, out_tready;
    logic [31:0] out_tdata;

    always #4 clk = ~clk;

    wb_axi_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
        .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .axi_awvalid(axi_awvalid), .axi_awready(axi_awready), .axi_awaddr(axi_awaddr),
        .axi_wvalid(axi_wvalid), .axi_wready(axi_wready), .axi_wdata(axi_wdata), .axi_wstrb(axi_wstrb),
        .axi_arvalid(axi_arvalid), .axi_arready(axi_arready), .axi_araddr(axi_araddr),
        .axi_rvalid(axi_rvalid), .axi_rready(axi_rready), .axi_rdata(axi_rdata),
        .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tdata(in_tdata),
        .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tdata(out_tdata)
    );

    int checks = 0;
    int failures = 0;

    // AXI side model controls and observations
    int aw_dly = 0, w_dly = 0, ar_dly = 0, r_dly = 0, ps_dly = 0, pl_dly = 0;
    int aw_c, w_c, ar_c, r_c, ps_c, pl_c;
    logic r_pend;
    logic [11:0] got_awaddr, got_araddr;
    logic [31:0] got_wdata;
    logic [3:0]  got_wstrb;
    int aw_hs, w_hs, ar_hs, r_hs;
    logic [31:0] sink_mem [0:7];
    int sink_n;
    logic [31:0] src_mem [0:7];
    int src_n = 0;
    int src_idx;
    int act_cnt, multi_cnt, tready_bad, ack_bad;
    logic prev_tready, prev_ack;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            axi_awready <= 0; axi_wready <= 0; axi_arready <= 0; axi_rvalid <= 0;
            axi_rdata <= '0; in_tready <= 0; out_tvalid <= 0; out_tdata <= '0;
            aw_c <= 0; w_c <= 0; ar_c <= 0; r_c <= 0; ps_c <= 0; pl_c <= 0; r_pend <= 0;
            got_awaddr <= '0; got_araddr <= '0; got_wdata <= '0; got_wstrb <= '0;
            aw_hs <= 0; w_hs <= 0; ar_hs <= 0; r_hs <= 0; sink_n <= 0; src_idx <= 0;
            act_cnt <= 0; multi_cnt <= 0; tready_bad <= 0; ack_bad <= 0;
            prev_tready <= 0; prev_ack <= 0;
        end else begin
            if (axi_awvalid && axi_awready) begin
                aw_hs <= aw_hs + 1; got_awaddr <= axi_awaddr; axi_awready <= 0;
            end else if (axi_awvalid) begin
                if (aw_c >= aw_dly) begin axi_awready <= 1; aw_c <= 0; end else aw_c <= aw_c + 1;
            end
            if (axi_wvalid && axi_wready) begin
                w_hs <= w_hs + 1; got_wdata <= axi_wdata; got_wstrb <= axi_wstrb; axi_wready <= 0;
            end else if (axi_wvalid) begin
                if (w_c >= w_dly) begin axi_wready <= 1; w_c <= 0; end else w_c <= w_c + 1;
            end
            if (axi_arvalid && axi_arready) begin
                ar_hs <= ar_hs + 1; got_araddr <= axi_araddr; axi_arready <= 0;
                r_pend <= 1; r_c <= 0; axi_rdata <= 32'hC0DE_0000 ^ {20'd0, axi_araddr};
            end else if (axi_arvalid) begin
                if (ar_c >= ar_dly) begin axi_arready <= 1; ar_c <= 0; end else ar_c <= ar_c + 1;
            end
            if (axi_rvalid && axi_rready) begin
                axi_rvalid <= 0; r_hs <= r_hs + 1;
            end else if (r_pend && !axi_rvalid) begin
                if (r_c >= r_dly) begin axi_rvalid <= 1; r_pend <= 0; end else r_c <= r_c + 1;
            end
            if (in_tvalid && in_tready) begin
                sink_mem[sink_n % 8] <= in_tdata; sink_n <= sink_n + 1; in_tready <= 0;
            end else if (in_tvalid) begin
                if (ps_c >= ps_dly) begin in_tready <= 1; ps_c <= 0; end else ps_c <= ps_c + 1;
            end
            if (out_tvalid && out_tready) begin
                out_tvalid <= 0; src_idx <= src_idx + 1; pl_c <= 0;
            end else if (!out_tvalid && src_idx < src_n) begin
                if (pl_c >= pl_dly) begin
                    out_tvalid <= 1; out_tdata <= src_mem[src_idx % 8]; pl_c <= 0;
                end else pl_c <= pl_c + 1;
            end
            if (axi_awvalid || axi_wvalid || axi_arvalid || axi_rready || in_tvalid || out_tready)
                act_cnt <= act_cnt + 1;
            if ($countones({axi_awvalid || axi_wvalid, axi_arvalid || axi_rready, in_tvalid, out_tready}) > 1)
                multi_cnt <= multi_cnt + 1;
            if (out_tready && prev_tready) tready_bad <= tready_bad + 1;
            if (wb_ack && prev_ack) ack_bad <= ack_bad + 1;
            prev_tready <= out_tready;
            prev_ack <= wb_ack;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wb_access(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                             input logic [3:0] sel, input int limit,
                             output logic [31:0] rd, output int lat, output bit acked);
        wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = adr; wb_dat_w = dat; wb_sel = sel;
        lat = 0; acked = 0; rd = '0;
        while (!acked && lat < limit) begin
            @(negedge clk);
            lat++;
            if (wb_ack) begin acked = 1; rd = wb_dat_r; end
        end
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
    endtask

    task automatic t_reset();
        chk({wb_ack, axi_awvalid, axi_wvalid, axi_arvalid, axi_rready, in_tvalid, out_tready} == 7'b0,
            "R9", "outputs idle after reset",
            {25'd0, wb_ack, axi_awvalid, axi_wvalid, axi_arvalid, axi_rready, in_tvalid, out_tready}, 32'd0);
    endtask

    task automatic lite_wr_case(input logic [15:0] ofs, input logic [31:0] d, input logic [3:0] s,
                                input int ad, input int wd);
        logic [31:0] rd; int lat; bit ok; int aw0, w0; int exp_lat;
        aw_dly = ad; w_dly = wd; aw0 = aw_hs; w0 = w_hs;
        exp_lat = 3 + ((ad > wd) ? ad : wd);
        wb_access(1'b1, {16'h3000, ofs}, d, s, 60, rd, lat, ok);
        chk(ok, "R2", "register write acknowledged", {31'd0, ok}, 32'd1);
        chk(got_awaddr == ofs[11:0], "R2", "awaddr", {20'd0, got_awaddr}, {20'd0, ofs[11:0]});
        chk(got_wdata == d, "R2", "wdata", got_wdata, d);
        chk(got_wstrb == s, "R2", "wstrb", {28'd0, got_wstrb}, {28'd0, s});
        chk(aw_hs == aw0 + 1 && w_hs == w0 + 1, "R2", "one beat per channel",
            aw_hs - aw0 + (w_hs - w0) * 16, 32'h11);
        chk(lat == exp_lat, "R8", "write ack latency", lat, exp_lat);
        @(negedge clk);
    endtask

    task automatic t_lite_write();
        lite_wr_case(16'h0000, 32'h0000_0001, 4'b0011, 0, 0);
        lite_wr_case(16'h0010, 32'h0000_0040, 4'b1111, 3, 1);
        lite_wr_case(16'h0014, 32'h0000_000B, 4'b1111, 0, 4);
        lite_wr_case(16'h0080, 32'hFFFF_FFF6, 4'b1111, 2, 2);
        lite_wr_case(16'h0FFC, 32'h1234_5678, 4'b1000, 1, 0);
    endtask

    task automatic lite_rd_case(input logic [15:0] ofs, input int ad, input int rdl);
        logic [31:0] rd; int lat; bit ok; int exp_lat; logic [31:0] exp_d;
        ar_dly = ad; r_dly = rdl;
        exp_lat = 5 + ad + rdl;
        exp_d = 32'hC0DE_0000 ^ {20'd0, ofs[11:0]};
        wb_access(1'b0, {16'h3000, ofs}, 32'd0, 4'hF, 60, rd, lat, ok);
        chk(ok, "R3", "register read acknowledged", {31'd0, ok}, 32'd1);
        chk(got_araddr == ofs[11:0], "R3", "araddr", {20'd0, got_araddr}, {20'd0, ofs[11:0]});
        chk(rd == exp_d, "R3", "read data", rd, exp_d);
        chk(lat == exp_lat, "R8", "read ack latency", lat, exp_lat);
        @(negedge clk);
    endtask

    task automatic t_lite_read();
        lite_rd_case(16'h0014, 0, 0);
        lite_rd_case(16'h0100, 2, 3);
        lite_rd_case(16'h0000, 0, 5);
    endtask

    task automatic t_push();
        logic [31:0] rd; int lat; bit ok; int n0;
        n0 = sink_n;
        for (int i = 0; i < 3; i++) begin
            ps_dly = i * 2;
            wb_access(1'b1, 32'h3000_0040, 32'hA000_0000 + i, 4'hF, 60, rd, lat, ok);
            chk(ok && lat == 3 + i * 2, "R4", "push ack latency", lat, 3 + i * 2);
            @(negedge clk);
        end
        chk(sink_n == n0 + 3, "R6", "pushed beat count", sink_n - n0, 3);
        for (int i = 0; i < 3; i++)
            chk(sink_mem[(n0 + i) % 8] == 32'hA000_0000 + i, "R4", "pushed sample",
                sink_mem[(n0 + i) % 8], 32'hA000_0000 + i);
    endtask

    task automatic t_pull();
        logic [31:0] rd; int lat; bit ok; int i0;
        pl_dly = 0; i0 = src_idx;
        src_mem[src_n % 8] = 32'h5151_0001; src_mem[(src_n + 1) % 8] = 32'h5151_0002;
        src_n = src_n + 2;
        repeat (3) @(negedge clk);
        for (int i = 1; i <= 2; i++) begin
            wb_access(1'b0, 32'h3000_0044, 32'd0, 4'hF, 60, rd, lat, ok);
            chk(ok && rd == 32'h5151_0000 + i, "R5", "pulled sample", rd, 32'h5151_0000 + i);
            chk(lat == 3, "R5", "pull latency with sample waiting", lat, 3);
            repeat (2) @(negedge clk);
        end
        chk(src_idx == i0 + 2, "R6", "pulled beat count", src_idx - i0, 2);
    endtask

    task automatic t_pull_stall();
        logic [31:0] rd; int lat; bit ok; int i0;
        i0 = src_idx; pl_dly = 0;
        fork
            wb_access(1'b0, 32'h3000_0044, 32'd0, 4'hF, 80, rd, lat, ok);
            begin
                repeat (10) @(negedge clk);
                src_mem[src_n % 8] = 32'h7E57_00AA;
                src_n = src_n + 1;
            end
        join
        chk(ok && rd == 32'h7E57_00AA, "R5", "late sample returned", rd, 32'h7E57_00AA);
        chk(lat > 10, "R5", "ack waits for tvalid", lat, 11);
        chk(src_idx == i0 + 1, "R6", "single beat on stalled pull", src_idx - i0, 1);
        @(negedge clk);
    endtask

    task automatic t_window();
        logic [31:0] rd; int lat; bit ok; int a0;
        a0 = act_cnt;
        wb_access(1'b1, 32'h3100_0040, 32'hDEAD_BEEF, 4'hF, 20, rd, lat, ok);
        chk(!ok, "R1", "no ack outside window (write)", {31'd0, ok}, 32'd0);
        @(negedge clk);
        wb_access(1'b0, 32'h2000_0010, 32'd0, 4'hF, 20, rd, lat, ok);
        chk(!ok, "R1", "no ack outside window (read)", {31'd0, ok}, 32'd0);
        chk(act_cnt == a0, "R1", "no AXI activity outside window", act_cnt - a0, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_null();
        logic [31:0] rd; int lat; bit ok; int a0, i0;
        pl_dly = 0;
        src_mem[src_n % 8] = 32'h0BAD_F00D; src_n = src_n + 1;
        repeat (3) @(negedge clk);
        a0 = act_cnt; i0 = src_idx;
        wb_access(1'b1, 32'h3000_0044, 32'h1111_1111, 4'hF, 20, rd, lat, ok);
        chk(ok && lat == 1, "R7", "write to pull offset acked at once", lat, 1);
        @(negedge clk);
        wb_access(1'b0, 32'h3000_0040, 32'd0, 4'hF, 20, rd, lat, ok);
        chk(ok && rd == 32'd0, "R7", "read of push offset is zero", rd, 0);
        @(negedge clk);
        wb_access(1'b0, 32'h3000_0004, 32'd0, 4'hF, 20, rd, lat, ok);
        chk(ok && rd == 32'd0 && lat == 1, "R7", "unlisted offset reads zero", rd, 0);
        @(negedge clk);
        wb_access(1'b1, 32'h3000_2000, 32'h2222_2222, 4'hF, 20, rd, lat, ok);
        chk(ok && lat == 1, "R7", "offset above register span acked at once", lat, 1);
        chk(act_cnt == a0 && src_idx == i0, "R7", "no AXI activity, queue intact",
            act_cnt - a0 + src_idx - i0, 0);
        @(negedge clk);
        wb_access(1'b0, 32'h3000_0044, 32'd0, 4'hF, 60, rd, lat, ok);
        chk(ok && rd == 32'h0BAD_F00D, "R7", "queued sample survives ignored accesses", rd, 32'h0BAD_F00D);
        @(negedge clk);
    endtask

    task automatic t_final();
        chk(multi_cnt == 0, "R8", "overlapping AXI operations", multi_cnt, 0);
        chk(ack_bad == 0, "R8", "ack longer than one cycle", ack_bad, 0);
        chk(tready_bad == 0, "R5", "out_tready longer than one cycle", tready_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog run did not finish actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_lite_write();
        t_lite_read();
        t_push();
        t_pull();
        t_pull_stall();
        t_window();
        t_null();
        t_final();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule